// File: doc/BRIEF.md
# Request-Paced Looping Byte Mover

This block is a one-channel transfer engine that copies a byte array from a synchronous memory read port to one fixed peripheral register. Each byte is one burst, and each burst is started by one rising edge on the request input. A request input driven by a slow periodic strobe, for example 100 kHz, therefore sets the output byte rate. A single descriptor holds the byte count, the source base, the destination register address and a set of option flags. One flag links the descriptor back to itself, so the array is replayed with no limit and no processor help.

Before the channel is enabled, software loads the descriptor through a small write port. The enable input is then raised. Two flags control the run. The auto-execute flag lets the engine stream bytes back to back and ignore requests. The preserve flag decides whether each new pass restarts at the original base address or continues from the address after the last byte read. A one-cycle terminal pulse can mark the final byte of every pass.

Top module: `dma_loop_engine`

## Requirements
- R1: While reset is held, mem_rd_en, per_wr_en and term_pulse are all low.
- R2: In paced mode (flag bit 2 clear), a request rising edge first sampled at clock edge E0 gives mem_rd_en with the current source address in the cycle after E0. The matching per_wr_en, carrying that byte, is high in the cycle after the third edge counted from E0.
- R3: A request held high for several cycles starts exactly one byte.
- R4: A request edge that arrives while a byte is moving is kept in a single pending slot and served next. Any further edge that arrives before the slot is served is lost.
- R5: Bytes of one pass are written in ascending source order when flag bit 0 (source increment) is set. Every write goes to the destination address held in descriptor slot 2.
- R6: With flag bit 4 (self link) and flag bit 3 (preserve) set, each new pass reloads the count from slot 0 and the source from slot 1, so the array replays from its first byte.
- R7: With self link set and preserve clear, the next pass starts at the address after the last byte read. That advanced address is kept as the stored source, so a later re-enable also continues from it.
- R8: With self link clear, the engine stops after one pass and ignores requests until the enable input goes low and then high again.
- R9: With flag bit 2 (auto-execute) set, bytes are written one every 3 cycles from the moment the engine is enabled, and requests have no effect.
- R10: term_pulse is high for one cycle, together with the write of the last byte of a pass, and only when flag bit 1 is set.
- R11: Dropping the enable input lets a byte already being read finish its write. After that the engine is idle and does no further reads or writes.
- R12: Descriptor writes (cfg_addr 0 count, 1 source, 2 destination, 3 flags) take effect only while the engine is idle and are ignored while it runs.
- R13: With flag bit 0 clear, every byte of every pass is read from the same source address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_addr | input | 2 | Descriptor slot select |
| cfg_wdata | input | ADDR_W | Descriptor write value |
| ch_en | input | 1 | Channel enable level |
| req | input | 1 | Transfer request strobe |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 8 | Memory read data, one cycle after mem_rd_en |
| per_wr_en | output | 1 | Peripheral register write enable |
| per_wr_addr | output | ADDR_W | Peripheral register address |
| per_wr_data | output | 8 | Peripheral register write data |
| term_pulse | output | 1 | End-of-pass pulse |

## Verification
In paced mode a byte's read is due in the cycle after the edge that samples the request. Its write is due in the cycle after the third such edge. The bench checks both at the exact falling edges that follow those clock edges. In auto mode the writes must be spaced exactly 3 cycles apart, and the monitor measures that spacing with its own cycle counter. All other results go into a scoreboard queue in the order they are due. The monitor pops one item for each observed write and flags any write it did not expect. After each scenario the bench waits well past the last due cycle and then requires the queue to be empty.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_RD,
    SQ_CAP,
    SQ_WR,
    SQ_DONE
  } seq_state_t;

  localparam int FLAG_W      = 5;
  localparam int FL_INC      = 0;
  localparam int FL_TERM     = 1;
  localparam int FL_AUTO     = 2;
  localparam int FL_PRESERVE = 3;
  localparam int FL_LINK     = 4;

  localparam logic [1:0] SLOT_COUNT = 2'd0;
  localparam logic [1:0] SLOT_SRC   = 2'd1;
  localparam logic [1:0] SLOT_DST   = 2'd2;
  localparam logic [1:0] SLOT_FLAGS = 2'd3;

endpackage

// File: rtl/dma_req_tracker.sv
module dma_req_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic flush,
  input  logic take,
  output logic rise,
  output logic trigger
);
  logic req_q;
  logic pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      req_q <= req;
      if (flush) pending_q <= 1'b0;
      else       pending_q <= (pending_q | rise) & ~take;
    end
  end

  assign rise    = req & ~req_q;
  assign trigger = pending_q | rise;
endmodule

// File: rtl/dma_desc_store.sv
module dma_desc_store
  import dma_loop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              cfg_open,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_src,
  output logic [CNT_W-1:0]  d_cnt,
  output logic [ADDR_W-1:0] d_src,
  output logic [ADDR_W-1:0] d_dst,
  output logic [FLAG_W-1:0] d_flags
);
  logic cfg_hit;
  assign cfg_hit = cfg_we & cfg_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_cnt   <= '0;
      d_src   <= '0;
      d_dst   <= '0;
      d_flags <= '0;
    end else begin
      if (cfg_hit && cfg_addr == SLOT_COUNT) d_cnt <= cfg_wdata[CNT_W-1:0];
      if (cfg_hit && cfg_addr == SLOT_DST)   d_dst <= cfg_wdata;
      if (cfg_hit && cfg_addr == SLOT_FLAGS) d_flags <= cfg_wdata[FLAG_W-1:0];
      if (cfg_hit && cfg_addr == SLOT_SRC)   d_src <= cfg_wdata;
      else if (wb_en)                        d_src <= wb_src;
    end
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_loop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_en,
  input  logic              trigger,
  input  logic [CNT_W-1:0]  d_cnt,
  input  logic [ADDR_W-1:0] d_src,
  input  logic [ADDR_W-1:0] d_dst,
  input  logic [FLAG_W-1:0] d_flags,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              per_wr_en,
  output logic [ADDR_W-1:0] per_wr_addr,
  output logic [7:0]        per_wr_data,
  output logic              term_pulse,
  output logic              take,
  output logic              idle,
  output logic              auto_run,
  output logic              pass_end,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_src
);
  seq_state_t          st;
  logic [ADDR_W-1:0]   cur_src;
  logic [CNT_W-1:0]    cur_cnt;
  logic [ADDR_W-1:0]   run_dst;
  logic [FLAG_W-1:0]   run_flags;
  logic [7:0]          data_q;
  logic [ADDR_W-1:0]   src_adv;

  function automatic logic [ADDR_W-1:0] step_src(input logic [ADDR_W-1:0] a, input logic inc);
    return inc ? a + 1'b1 : a;
  endfunction

  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  assign src_adv   = step_src(cur_src, run_flags[FL_INC]);
  assign auto_run  = run_flags[FL_AUTO];
  assign idle      = (st == SQ_IDLE);
  assign take      = (st == SQ_WAIT) & ch_en & trigger;
  assign pass_end  = (st == SQ_WR) & is_last(cur_cnt);
  assign wb_en     = pass_end & ~run_flags[FL_PRESERVE];
  assign wb_src    = src_adv;

  assign mem_rd_en   = (st == SQ_RD);
  assign mem_rd_addr = cur_src;
  assign per_wr_en   = (st == SQ_WR);
  assign per_wr_addr = run_dst;
  assign per_wr_data = data_q;
  assign term_pulse  = pass_end & run_flags[FL_TERM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      cur_src   <= '0;
      cur_cnt   <= '0;
      run_dst   <= '0;
      run_flags <= '0;
      data_q    <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (ch_en) begin
            cur_src   <= d_src;
            cur_cnt   <= d_cnt;
            run_dst   <= d_dst;
            run_flags <= d_flags;
            st        <= d_flags[FL_AUTO] ? SQ_RD : SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (!ch_en)       st <= SQ_IDLE;
          else if (trigger) st <= SQ_RD;
        end
        SQ_RD:  st <= SQ_CAP;
        SQ_CAP: begin
          data_q <= mem_rd_data;
          st     <= SQ_WR;
        end
        SQ_WR: begin
          if (is_last(cur_cnt)) begin
            cur_cnt <= d_cnt;
            cur_src <= run_flags[FL_PRESERVE] ? d_src : src_adv;
            if (!ch_en)                  st <= SQ_IDLE;
            else if (!run_flags[FL_LINK]) st <= SQ_DONE;
            else                          st <= auto_run ? SQ_RD : SQ_WAIT;
          end else begin
            cur_cnt <= cur_cnt - 1'b1;
            cur_src <= src_adv;
            if (!ch_en) st <= SQ_IDLE;
            else        st <= auto_run ? SQ_RD : SQ_WAIT;
          end
        end
        SQ_DONE: begin
          if (!ch_en) st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
  import dma_loop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              ch_en,
  input  logic              req,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              per_wr_en,
  output logic [ADDR_W-1:0] per_wr_addr,
  output logic [7:0]        per_wr_data,
  output logic              term_pulse
);
  logic              req_rise;
  logic              req_trigger;
  logic              req_take;
  logic              seq_idle;
  logic              auto_run;
  logic              pass_end;
  logic              wb_en;
  logic [ADDR_W-1:0] wb_src;
  logic [CNT_W-1:0]  d_cnt;
  logic [ADDR_W-1:0] d_src;
  logic [ADDR_W-1:0] d_dst;
  logic [FLAG_W-1:0] d_flags;

  dma_req_tracker u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .flush   (seq_idle),
    .take    (req_take),
    .rise    (req_rise),
    .trigger (req_trigger)
  );

  dma_desc_store #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_desc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_open  (seq_idle),
    .wb_en     (wb_en),
    .wb_src    (wb_src),
    .d_cnt     (d_cnt),
    .d_src     (d_src),
    .d_dst     (d_dst),
    .d_flags   (d_flags)
  );

  dma_xfer_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en       (ch_en),
    .trigger     (req_trigger),
    .d_cnt       (d_cnt),
    .d_src       (d_src),
    .d_dst       (d_dst),
    .d_flags     (d_flags),
    .mem_rd_data (mem_rd_data),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .per_wr_en   (per_wr_en),
    .per_wr_addr (per_wr_addr),
    .per_wr_data (per_wr_data),
    .term_pulse  (term_pulse),
    .take        (req_take),
    .idle        (seq_idle),
    .auto_run    (auto_run),
    .pass_end    (pass_end),
    .wb_en       (wb_en),
    .wb_src      (wb_src)
  );
endmodule

// File: rtl/dma_loop_checker.sv
module dma_loop_checker (
  input logic clk,
  input logic rst_n,
  input logic ch_en,
  input logic mem_rd_en,
  input logic per_wr_en,
  input logic term_pulse,
  input logic req_take,
  input logic auto_run,
  input logic seq_idle
);
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && per_wr_en)); // R2

  AST_WRITE_TWO_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr_en |-> $past(mem_rd_en, 2)); // R2

  AST_PACED_READ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !auto_run) |-> $past(req_take)); // R4

  AST_TERM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |-> per_wr_en); // R10

  AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |=> !term_pulse); // R10

  AST_READ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> $past(ch_en)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> !(mem_rd_en || per_wr_en)); // R11
endmodule

bind dma_loop_engine dma_loop_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_en      (ch_en),
  .mem_rd_en  (mem_rd_en),
  .per_wr_en  (per_wr_en),
  .term_pulse (term_pulse),
  .req_take   (req_take),
  .auto_run   (auto_run),
  .seq_idle   (seq_idle)
);

// File: tb/dma_loop_engine_test.sv
module dma_loop_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          ch_en = 1'b0;
  logic          req = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    mem_rd_data = 8'h00;
  logic          per_wr_en;
  logic [AW-1:0] per_wr_addr;
  logic [7:0]    per_wr_data;
  logic          term_pulse;

  dma_loop_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ch_en(ch_en), .req(req),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .per_wr_en(per_wr_en), .per_wr_addr(per_wr_addr), .per_wr_data(per_wr_data),
    .term_pulse(term_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: byte value equals low address byte, one cycle latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_rd_addr[7:0];

  typedef struct packed { logic [7:0] d; logic [AW-1:0] a; logic t; } exp_t;
  exp_t exp_q[$];

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int nwr = 0;
  int last_wr = -1;
  bit gap_on = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [AW-1:0] a, input logic t);
    exp_t e;
    e.d = d; e.a = a; e.t = t;
    exp_q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (term_pulse && !per_wr_en) chk(1'b0, "R10 term without write", 1, 0);
      if (per_wr_en) begin
        nwr++;
        if (gap_on && last_wr >= 0) chk(cyc - last_wr == 3, "R9 write spacing", cyc - last_wr, 3);
        last_wr = cyc;
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write", per_wr_data, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(per_wr_data == e.d, "R5 data", per_wr_data, e.d);
          chk(per_wr_addr == e.a, "R5 dest", per_wr_addr, e.a);
          chk(term_pulse == e.t, "R10 term", term_pulse, e.t);
        end
      end
    end
  end

  task automatic cfg(input logic [1:0] a, input logic [AW-1:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [7:0] cnt, input logic [AW-1:0] src, input logic [AW-1:0] dst, input logic [4:0] fl);
    cfg(2'd0, AW'(cnt)); cfg(2'd1, src); cfg(2'd2, dst); cfg(2'd3, AW'(fl));
  endtask

  task automatic pulse(input int width, input int gap);
    @(negedge clk); req = 1'b1;
    repeat (width) @(negedge clk);
    req = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic cycle_enable();
    @(negedge clk); ch_en = 1'b0;
    repeat (3) @(negedge clk); ch_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!mem_rd_en && !per_wr_en && !term_pulse, "R1 reset outputs", {mem_rd_en, per_wr_en, term_pulse}, 0);
    rst_n = 1'b1;

    // paced, self link, preserve, terminal enabled
    setup(8'd4, 16'h0100, 16'h0020, 5'h1B);
    @(negedge clk); ch_en = 1'b1;
    repeat (4) @(negedge clk);

    // R2 latency of first byte
    push(8'd0, 16'h0020, 1'b0);
    req = 1'b1;
    @(posedge clk);
    @(negedge clk); req = 1'b0;
    chk(mem_rd_en == 1'b1, "R2 read cycle", mem_rd_en, 1);
    chk(mem_rd_addr == 16'h0100, "R2 read addr", mem_rd_addr, 16'h0100);
    @(negedge clk);
    chk(per_wr_en == 1'b0, "R2 no early write", per_wr_en, 0);
    @(negedge clk);
    chk(per_wr_en == 1'b1, "R2 write cycle", per_wr_en, 1);
    repeat (4) @(negedge clk);

    // R3 held request: one byte
    push(8'd1, 16'h0020, 1'b0);
    pulse(6, 6);

    // R4 three rising edges inside one transfer window: two bytes
    push(8'd2, 16'h0020, 1'b0);
    push(8'd3, 16'h0020, 1'b1);
    req = 1'b1; @(negedge clk); req = 1'b0; @(negedge clk);
    req = 1'b1; @(negedge clk); req = 1'b0; @(negedge clk);
    req = 1'b1; @(negedge clk); req = 1'b0;
    drain("R4 pending slot");

    // R6 replay from base
    for (int i = 0; i < 4; i++) begin
      push(8'(i), 16'h0020, i == 3);
      pulse(1, 6);
    end
    drain("R6 replay");

    // R12 config write while running is ignored
    cfg(2'd2, 16'h0055);
    cycle_enable();
    push(8'd0, 16'h0020, 1'b0);
    pulse(1, 6);
    drain("R12 dest unchanged");

    // R7 no preserve: continue from advanced address
    @(negedge clk); ch_en = 1'b0;
    setup(8'd2, 16'h0100, 16'h0030, 5'h11);
    @(negedge clk); ch_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      push(8'(i), 16'h0030, 1'b0);
      pulse(1, 6);
    end
    drain("R7 continue");
    cycle_enable();
    push(8'd4, 16'h0030, 1'b0);
    pulse(1, 6);
    drain("R7 stored source advanced");

    // R8 link clear: one pass then stop
    @(negedge clk); ch_en = 1'b0;
    setup(8'd3, 16'h0100, 16'h0040, 5'h0B);
    @(negedge clk); ch_en = 1'b1;
    for (int i = 0; i < 3; i++) push(8'(i), 16'h0040, i == 2);
    for (int i = 0; i < 5; i++) pulse(1, 6);
    drain("R8 single pass");
    cycle_enable();
    push(8'd0, 16'h0040, 1'b0);
    pulse(1, 6);
    drain("R8 restart");

    // R13 no source increment
    @(negedge clk); ch_en = 1'b0;
    setup(8'd3, 16'h0105, 16'h0041, 5'h1A);
    @(negedge clk); ch_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      push(8'd5, 16'h0041, i == 2);
      pulse(1, 6);
    end
    drain("R13 fixed source");

    // R11 disable during a byte: it completes, then idle
    @(negedge clk); ch_en = 1'b0;
    setup(8'd4, 16'h0100, 16'h0020, 5'h1B);
    @(negedge clk); ch_en = 1'b1;
    repeat (3) @(negedge clk);
    push(8'd0, 16'h0020, 1'b0);
    req = 1'b1;
    @(posedge clk);
    @(negedge clk); req = 1'b0; ch_en = 1'b0;
    repeat (6) @(negedge clk);
    pulse(1, 6);
    drain("R11 finish then idle");
    chk(nwr > 0 && !mem_rd_en, "R11 no read when off", mem_rd_en, 0);

    // R9 auto-execute: back to back, requests ignored
    setup(8'd4, 16'h0100, 16'h0060, 5'h1F);
    for (int i = 0; i < 10; i++) push(8'(i % 4), 16'h0060, (i % 4) == 3);
    begin
      int target;
      target = nwr + 10;
      gap_on = 1'b1; last_wr = -1;
      @(negedge clk); ch_en = 1'b1; req = 1'b1;
      while (nwr < target) begin
        @(negedge clk); #1;
      end
      ch_en = 1'b0; req = 1'b0;
    end
    drain("R9 auto stream");
    gap_on = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule